// File: doc/BRIEF.md
# I2C Master Byte-Count Sequencer

This block runs the byte-level order of events in an I2C master transfer. A set of register-style strobes and configuration bits drives it. Behind it sits a byte engine that shifts single bytes on the wire and reports back through a request/done handshake. A START request loads an 8-bit byte count. The block then asks the engine for an address phase, followed by one data phase per byte, in transmit or receive direction. Each data byte lowers the count by one.

A single count segment carries at most 255 bytes. Longer transfers run in reload mode. When a segment's count runs out, the block holds the clock low and raises a reload flag. Software then writes the next non-zero count, and the data phases carry on without another address phase. When the count runs out with reload off, there are two outcomes. If automatic end is on, the block issues STOP by itself. If it is off, the block holds the bus with a transfer-complete flag until software asks for STOP or for a repeated START.

Per byte, the block raises a transmit-request flag while the single-byte transmit buffer is empty and data is still owed. It raises a receive-full flag when a received byte is waiting. Each flag has an interrupt enable. If the engine reports a NACK on an address or transmit byte, the transfer aborts to STOP and an error flag is set.

Top module: `i2c_lenseq`

## Requirements
- R1: After reset the block is idle: busy, eng_req, all flags, irq, scl_hold and cnt_left are 0.
- R2: A sw_start pulse in idle loads cnt_left from the last written count and issues an address request (eng_op = 0). eng_dir carries the direction taken from cfg_rx (1 = receive). In transmit mode with a non-zero count, flag_ti is raised at once.
- R3: In transmit mode a data request (eng_op = 1) is raised only while the transmit buffer holds a byte. The engine receives the bytes in the order tx_wr wrote them, and a tx_wr write clears flag_ti.
- R4: Each completed data byte lowers cnt_left by exactly one.
- R5: In receive mode each completed byte appears on rx_data and sets flag_rbne, and an rx_rd strobe clears it. While flag_rbne is set, no further data request is raised and scl_hold is 1.
- R6: irq equals (flag_ti AND ie_ti) OR (flag_rbne AND ie_rbne).
- R7: With cfg_reload = 1, the end of a count sets flag_tcr and scl_hold, and raises no request. A count write of zero is ignored. A non-zero count write resumes data phases with that count and no new address phase.
- R8: With cfg_reload = 0 and cfg_autoend = 1, the end of a count issues one stop request (eng_op = 2), after which the block returns to idle.
- R9: With cfg_reload = 0 and cfg_autoend = 0, the end of a count sets flag_tc and scl_hold. sw_stop leads to a stop request, and sw_start leads to a new address phase with the newly written count. Either one clears flag_tc.
- R10: A NACK on an address or transmit data byte leads straight to a stop request and sets flag_err. The next START clears flag_err.
- R11: A zero count at START with automatic end performs the address phase, then a stop, and no data phase.
- R12: Transfers of 1, 255 and 300 bytes deliver exactly that many data phases under one address phase. The 300-byte transfer passes through exactly one reload stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_start | input | 1 | Strobe: request START / repeated START |
| sw_stop | input | 1 | Strobe: request STOP from the complete state |
| cfg_rx | input | 1 | Direction for the next START, 1 = receive |
| cfg_reload | input | 1 | Reload mode at end of count |
| cfg_autoend | input | 1 | Automatic STOP at end of count |
| cnt_wr | input | 1 | Strobe: write byte count |
| cnt_wdata | input | CNT_W | Byte count value |
| tx_wr | input | 1 | Strobe: write transmit byte |
| tx_wdata | input | DATA_W | Transmit byte |
| rx_rd | input | 1 | Strobe: read of received byte |
| ie_ti | input | 1 | Interrupt enable for flag_ti |
| ie_rbne | input | 1 | Interrupt enable for flag_rbne |
| eng_req | output | 1 | Byte engine request |
| eng_op | output | 2 | Engine operation: 0 address, 1 data, 2 stop |
| eng_dir | output | 1 | Direction, 1 = receive |
| eng_wdata | output | DATA_W | Byte to transmit |
| eng_done | input | 1 | Engine completion (counts only with eng_req) |
| eng_ack | input | 1 | Engine ACK (1) / NACK (0) result |
| eng_rdata | input | DATA_W | Byte received by the engine |
| rx_data | output | DATA_W | Received byte |
| cnt_left | output | CNT_W | Bytes remaining in the current segment |
| flag_ti | output | 1 | Transmit byte wanted |
| flag_rbne | output | 1 | Received byte waiting |
| flag_tcr | output | 1 | Reload count wanted |
| flag_tc | output | 1 | Transfer complete, bus held |
| flag_err | output | 1 | Transfer aborted by NACK |
| irq | output | 1 | Interrupt |
| scl_hold | output | 1 | Clock is being stretched |
| busy | output | 1 | Transfer in progress |

## Verification
The hardest condition to reach is the reload state while it is being fed a zero count. A segment must run all the way to its end with reload enabled. Software must then deliberately write a zero instead of the next count, and the block must hold with no request. The stimulus starts a short transmit transfer and turns reload on after START. It then stops servicing the reload flag, writes a zero, and watches the held outputs for several cycles before supplying a real count. A transmit NACK in mid-segment is reached the same way: the bench's engine model is told which byte index to refuse.

// File: rtl/i2c_lenseq_pkg.sv
package i2c_lenseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_RELOAD,
    ST_DONE,
    ST_STOP
  } seq_st_e;

  localparam logic [1:0] OP_ADDR = 2'd0;
  localparam logic [1:0] OP_DATA = 2'd1;
  localparam logic [1:0] OP_STOP = 2'd2;

  // Where a segment goes once its count has run out.
  function automatic seq_st_e end_of_count(input logic reload, input logic autoend);
    if (reload)  return ST_RELOAD;
    if (autoend) return ST_STOP;
    return ST_DONE;
  endfunction

endpackage

// File: rtl/lenseq_counter.sv
module lenseq_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] left,
  output logic             last,
  output logic             empty
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    left <= '0;
    else if (load) left <= load_val;
    else if (dec)  left <= left - CNT_ONE;
  end

  assign last  = (left == CNT_ONE);
  assign empty = (left == '0);

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> !empty) else $error("count decremented at zero"); // R4

endmodule

// File: rtl/lenseq_bufs.sv
module lenseq_bufs #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_wdata,
  input  logic              tx_take,
  input  logic              rx_put,
  input  logic [DATA_W-1:0] rx_in,
  input  logic              rx_rd,
  output logic              tx_full,
  output logic [DATA_W-1:0] tx_byte,
  output logic              rx_full,
  output logic [DATA_W-1:0] rx_byte
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_full <= 1'b0;
      tx_byte <= '0;
    end else if (flush) begin
      tx_full <= 1'b0;
    end else if (tx_wr) begin
      tx_full <= 1'b1;
      tx_byte <= tx_wdata;
    end else if (tx_take) begin
      tx_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_full <= 1'b0;
      rx_byte <= '0;
    end else if (rx_put) begin
      rx_full <= 1'b1;
      rx_byte <= rx_in;
    end else if (rx_rd) begin
      rx_full <= 1'b0;
    end
  end

  AST_RX_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    rx_put |-> !rx_full) else $error("receive byte overwritten"); // R5
  AST_TX_TAKE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take |-> tx_full) else $error("transmit byte sent from empty buffer"); // R3

endmodule

// File: rtl/i2c_lenseq.sv
module i2c_lenseq
  import i2c_lenseq_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_start,
  input  logic              sw_stop,
  input  logic              cfg_rx,
  input  logic              cfg_reload,
  input  logic              cfg_autoend,
  input  logic              cnt_wr,
  input  logic [CNT_W-1:0]  cnt_wdata,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_wdata,
  input  logic              rx_rd,
  input  logic              ie_ti,
  input  logic              ie_rbne,
  output logic              eng_req,
  output logic [1:0]        eng_op,
  output logic              eng_dir,
  output logic [DATA_W-1:0] eng_wdata,
  input  logic              eng_done,
  input  logic              eng_ack,
  input  logic [DATA_W-1:0] eng_rdata,
  output logic [DATA_W-1:0] rx_data,
  output logic [CNT_W-1:0]  cnt_left,
  output logic              flag_ti,
  output logic              flag_rbne,
  output logic              flag_tcr,
  output logic              flag_tc,
  output logic              flag_err,
  output logic              irq,
  output logic              scl_hold,
  output logic              busy
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  seq_st_e          st;
  logic             mode_rx, err_q;
  logic [CNT_W-1:0] cnt_reg;

  // named internal events
  logic in_addr, in_data, in_stop;
  logic data_ready, byte_done, nack_abort, seg_end;
  logic reload_ok, start_go, cnt_load, cnt_dec;
  logic cnt_last, cnt_empty;
  logic tx_full, rx_full;
  logic [DATA_W-1:0] tx_byte;
  logic [CNT_W-1:0]  load_val;

  assign in_addr = (st == ST_ADDR);
  assign in_data = (st == ST_DATA);
  assign in_stop = (st == ST_STOP);

  assign data_ready = mode_rx ? !rx_full : tx_full;
  assign eng_req    = in_addr | in_stop | (in_data & data_ready);
  assign eng_op     = in_data ? OP_DATA : (in_stop ? OP_STOP : OP_ADDR);
  assign eng_dir    = mode_rx;
  assign eng_wdata  = tx_byte;

  assign byte_done  = eng_req & eng_done;
  assign nack_abort = byte_done & !eng_ack & (in_addr | (in_data & !mode_rx));
  assign seg_end    = byte_done & !nack_abort &
                      ((in_addr & cnt_empty) | (in_data & cnt_last));
  assign reload_ok  = (st == ST_RELOAD) & cnt_wr & (cnt_wdata != '0);
  assign start_go   = sw_start & ((st == ST_IDLE) | ((st == ST_DONE) & !sw_stop));

  assign cnt_load = start_go | reload_ok;
  assign load_val = reload_ok ? cnt_wdata : cnt_reg;
  assign cnt_dec  = in_data & byte_done;

  lenseq_counter #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(load_val),
    .dec(cnt_dec), .left(cnt_left), .last(cnt_last), .empty(cnt_empty)
  );

  lenseq_bufs #(.DATA_W(DATA_W)) u_bufs (
    .clk(clk), .rst_n(rst_n), .flush(start_go),
    .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_take(cnt_dec & !mode_rx),
    .rx_put(cnt_dec & mode_rx), .rx_in(eng_rdata), .rx_rd(rx_rd),
    .tx_full(tx_full), .tx_byte(tx_byte), .rx_full(rx_full), .rx_byte(rx_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      mode_rx <= 1'b0;
      err_q   <= 1'b0;
      cnt_reg <= '0;
    end else begin
      if (cnt_wr) cnt_reg <= cnt_wdata;
      if (start_go) begin
        mode_rx <= cfg_rx;
        err_q   <= 1'b0;
      end
      if (nack_abort) err_q <= 1'b1;
      unique case (st)
        ST_IDLE:   if (start_go) st <= ST_ADDR;
        ST_ADDR: begin
          if (nack_abort)     st <= ST_STOP;
          else if (seg_end)   st <= end_of_count(cfg_reload, cfg_autoend);
          else if (byte_done) st <= ST_DATA;
        end
        ST_DATA: begin
          if (nack_abort)   st <= ST_STOP;
          else if (seg_end) st <= end_of_count(cfg_reload, cfg_autoend);
        end
        ST_RELOAD: if (reload_ok) st <= ST_DATA;
        ST_DONE: begin
          if (sw_stop)       st <= ST_STOP;
          else if (start_go) st <= ST_ADDR;
        end
        ST_STOP:   if (byte_done) st <= ST_IDLE;
        default:   st <= ST_IDLE;
      endcase
    end
  end

  assign flag_ti   = !mode_rx & (in_addr | in_data) & !tx_full & !cnt_empty;
  assign flag_rbne = rx_full;
  assign flag_tcr  = (st == ST_RELOAD);
  assign flag_tc   = (st == ST_DONE);
  assign flag_err  = err_q;
  assign irq       = (flag_ti & ie_ti) | (flag_rbne & ie_rbne);
  assign scl_hold  = flag_tcr | flag_tc | (in_data & !data_ready);
  assign busy      = (st != ST_IDLE);

  AST_SEG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_dec && !cnt_last) |=> (cnt_left == $past(cnt_left) - CNT_ONE))
    else $error("count did not step by one"); // R4
  AST_TCR_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    reload_ok |=> (in_data && cnt_left == $past(cnt_wdata)))
    else $error("reload write did not resume data"); // R7
  AST_ZERO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_tcr && cnt_wr && cnt_wdata == '0) |=> flag_tcr)
    else $error("zero reload count released the hold"); // R7
  AST_NACK_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    nack_abort |=> (in_stop && flag_err))
    else $error("nack did not abort to stop"); // R10
  AST_TC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_tc && (sw_start || sw_stop)) |=> !flag_tc)
    else $error("complete flag not cleared"); // R9

endmodule

// File: tb/i2c_lenseq_test.sv
module i2c_lenseq_test;
  localparam int CNT_W  = 8;
  localparam int DATA_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sw_start, sw_stop, cfg_rx, cfg_reload, cfg_autoend, cnt_wr, tx_wr, rx_rd, ie_ti, ie_rbne;
  logic [CNT_W-1:0]  cnt_wdata;
  logic [DATA_W-1:0] tx_wdata, eng_wdata, eng_rdata, rx_data;
  logic eng_req, eng_dir, eng_done, eng_ack;
  logic [1:0] eng_op;
  logic [CNT_W-1:0] cnt_left;
  logic flag_ti, flag_rbne, flag_tcr, flag_tc, flag_err, irq, scl_hold, busy;

  i2c_lenseq #(.CNT_W(CNT_W), .DATA_W(DATA_W)) uut (.*);

  initial forever #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int n_addr, n_data, n_stop, tx_bad, rx_bad, rx_idx, tcr_seen, pend, wait_c;
  int nack_at = -1;
  bit rd_en = 1'b1, stop_on_tc = 1'b1;
  logic [7:0] tx_next;

  // {rx, autoend, total[9:0]}
  localparam logic [11:0] VEC [0:5] = '{
    {1'b0, 1'b1, 10'd1},   {1'b0, 1'b1, 10'd255}, {1'b0, 1'b1, 10'd300},
    {1'b1, 1'b1, 10'd300}, {1'b1, 1'b1, 10'd1},   {1'b0, 1'b1, 10'd0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // byte engine model: completes each request on the second cycle it is seen
  initial begin
    eng_done = 1'b0; eng_ack = 1'b1; eng_rdata = '0; wait_c = 0;
    forever begin
      @(negedge clk);
      if (eng_done) eng_done = 1'b0;
      else if (eng_req && rst_n) begin
        wait_c++;
        if (wait_c >= 2) begin
          wait_c = 0; eng_done = 1'b1; eng_ack = 1'b1;
          case (eng_op)
            2'd0: n_addr++;
            2'd1: begin
              if (!eng_dir) begin
                if (eng_wdata != 8'(8'h3C + n_data)) tx_bad++;
                if (n_data == nack_at) eng_ack = 1'b0;
              end else eng_rdata = 8'hA5 ^ 8'(n_data);
              n_data++;
            end
            default: n_stop++;
          endcase
        end
      end
    end
  end

  task automatic clr();
    sw_start = 0; sw_stop = 0; cnt_wr = 0; tx_wr = 0; rx_rd = 0;
  endtask

  // software model, one cycle
  task automatic svc();
    @(negedge clk); clr();
    if (flag_ti) begin tx_wr = 1; tx_wdata = tx_next; tx_next++; end
    if (flag_rbne && rd_en) begin
      if (rx_data != (8'hA5 ^ 8'(rx_idx))) rx_bad++;
      rx_idx++; rx_rd = 1;
    end
    if (flag_tcr && pend > 0) begin
      tcr_seen++;
      if (pend > 255) begin cnt_wdata = 8'hFF; pend -= 255; end
      else begin cnt_wdata = 8'(pend); pend = 0; end
      cfg_reload = (pend > 0); cnt_wr = 1;
    end
    if (flag_tc && stop_on_tc) sw_stop = 1;
  endtask

  task automatic begin_xfer(input bit rx, input int total, input bit ae);
    @(negedge clk); clr();
    cfg_rx = rx; cfg_autoend = ae;
    n_addr = 0; n_data = 0; n_stop = 0; tx_bad = 0; rx_bad = 0; rx_idx = 0; tcr_seen = 0;
    tx_next = 8'h3C;
    if (total > 255) begin cnt_wdata = 8'hFF; pend = total - 255; end
    else begin cnt_wdata = 8'(total); pend = 0; end
    cfg_reload = (pend > 0); cnt_wr = 1;
    @(negedge clk); cnt_wr = 0; sw_start = 1;
    @(negedge clk); sw_start = 0;
  endtask

  task automatic finish_xfer();
    for (int g = 0; g < 5000 && busy; g++) svc();
    @(negedge clk); clr();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected idle");
    summary(); $finish;
  end

  initial begin
    clr(); cfg_rx = 0; cfg_reload = 0; cfg_autoend = 1; cnt_wdata = 0; tx_wdata = 0;
    ie_ti = 0; ie_rbne = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0); chk("R1 eng_req", eng_req, 0);
    chk("R1 flags", {flag_ti, flag_rbne, flag_tcr, flag_tc, flag_err}, 0);
    chk("R1 irq", irq, 0); chk("R1 scl_hold", scl_hold, 0); chk("R1 cnt_left", cnt_left, 0);

    // vector table: R12 lengths, R8 autoend, R11 zero count, R7 reload
    for (int i = 0; i < 6; i++) begin
      automatic bit rx = VEC[i][11];
      automatic int total = int'(VEC[i][9:0]);
      begin_xfer(rx, total, VEC[i][10]);
      finish_xfer();
      chk($sformatf("R12 vec%0d data phases", i), n_data, total);
      chk($sformatf("R7 vec%0d address phases", i), n_addr, 1);
      chk($sformatf("R8 vec%0d stops", i), n_stop, 1);
      chk($sformatf("R7 vec%0d reload stops", i), tcr_seen, (total > 255) ? 1 : 0);
      chk($sformatf("R3 vec%0d tx order errors", i), tx_bad, 0);
      chk($sformatf("R5 vec%0d rx bytes read", i), rx_idx, rx ? total : 0);
      chk($sformatf("R5 vec%0d rx data errors", i), rx_bad, 0);
      chk($sformatf("R11 vec%0d idle", i), busy, 0);
    end

    // R2 / R3 / R6 start of a transmit transfer
    ie_ti = 1;
    begin_xfer(1'b0, 3, 1'b1);
    chk("R2 address request", {eng_req, eng_op}, {1'b1, 2'd0});
    chk("R2 direction", eng_dir, 0);
    chk("R2 count loaded", cnt_left, 3);
    chk("R2 flag_ti raised", flag_ti, 1);
    chk("R6 irq with ie_ti", irq, 1);
    ie_ti = 0; #1;
    chk("R6 irq masked", irq, 0);
    tx_wr = 1; tx_wdata = 8'h3C; tx_next = 8'h3D;
    @(negedge clk); clr();
    chk("R3 write clears flag_ti", flag_ti, 0);
    finish_xfer();
    chk("R4 three bytes", n_data, 3);
    chk("R4 count at end", cnt_left, 0);

    // R5 receive stall while byte unread
    ie_rbne = 1; rd_en = 0;
    begin_xfer(1'b1, 3, 1'b1);
    for (int g = 0; g < 200 && !flag_rbne; g++) svc();
    repeat (6) svc();
    chk("R5 no request while full", eng_req, 0);
    chk("R5 clock held", scl_hold, 1);
    chk("R5 one byte only", n_data, 1);
    chk("R6 irq with ie_rbne", irq, 1);
    chk("R4 count after one byte", cnt_left, 2);
    rd_en = 1;
    finish_xfer();
    chk("R5 all bytes read", rx_idx, 3);
    chk("R5 data ok", rx_bad, 0);
    ie_rbne = 0;

    // R7 zero reload count is ignored
    begin_xfer(1'b0, 2, 1'b1);
    cfg_reload = 1;
    for (int g = 0; g < 200 && !flag_tcr; g++) svc();
    @(negedge clk); clr(); cnt_wdata = 8'd0; cnt_wr = 1;
    repeat (3) svc();
    chk("R7 still in reload", flag_tcr, 1);
    chk("R7 clock held", scl_hold, 1);
    chk("R7 no request", eng_req, 0);
    chk("R7 count unchanged", cnt_left, 0);
    pend = 1;
    finish_xfer();
    chk("R7 data after reload", n_data, 3);
    chk("R7 single address phase", n_addr, 1);
    chk("R7 tx order", tx_bad, 0);

    // R9 complete hold, repeated start, then stop
    stop_on_tc = 0;
    begin_xfer(1'b1, 2, 1'b0);
    for (int g = 0; g < 200 && !flag_tc; g++) svc();
    @(negedge clk); clr();
    chk("R9 tc held", {flag_tc, scl_hold, eng_req}, 3'b110);
    chk("R9 two bytes", n_data, 2);
    cnt_wdata = 8'd1; cnt_wr = 1;
    @(negedge clk); cnt_wr = 0; sw_start = 1;
    @(negedge clk); sw_start = 0;
    chk("R9 restart clears tc", flag_tc, 0);
    chk("R9 restart address", {eng_req, eng_op}, {1'b1, 2'd0});
    for (int g = 0; g < 200 && !flag_tc; g++) svc();
    @(negedge clk); clr();
    chk("R9 second address", n_addr, 2);
    chk("R9 total bytes", n_data, 3);
    stop_on_tc = 1;
    finish_xfer();
    chk("R9 stop issued", n_stop, 1);
    chk("R9 idle", busy, 0);
    chk("R9 rx data", rx_bad, 0);

    // R10 NACK on second transmit byte
    nack_at = 1;
    begin_xfer(1'b0, 4, 1'b1);
    finish_xfer();
    nack_at = -1;
    chk("R10 error flag", flag_err, 1);
    chk("R10 stopped", n_stop, 1);
    chk("R10 bytes before abort", n_data, 2);
    chk("R10 count left", cnt_left, 2);
    chk("R10 idle", busy, 0);
    begin_xfer(1'b0, 1, 1'b1);
    chk("R10 start clears error", flag_err, 0);
    finish_xfer();
    chk("R10 next transfer ok", n_data, 1);
    chk("R3 fresh buffer order", tx_bad, 0);

    summary();
    $finish;
  end

endmodule